// File: doc/BRIEF.md
# Multi-Channel Gamma Correction Table

This block holds the gamma correction tables for a display pipeline with three output channels. Each channel owns one 256-entry table per colour component (red, green, blue), which gives 2,304 eight-bit entries in a single linear table space. Software fills the tables through a small register port. An index register selects the entry. A data register stores one byte at that index. When auto-advance is on, every data write moves the index forward by one, so a channel's tables can be filled by a burst of data writes after one index write.

Each channel has an 8-bit-per-component RGB pixel stream. When the channel's gamma switch is on, every component is replaced by the entry it indexes in that channel's table. When the switch is off, the pixel passes through unchanged. Both paths take one clock.

The table memory is powered only while at least one channel has gamma switched on or a keep-alive bit is set. While the memory is unpowered, the block treats every entry as lost, and a lookup of a lost entry returns zero. Software must reload the tables after it powers the memory again.

Top module: `gamma_lut_top`

## Requirements
- R1: After reset the index register reads 0 with both control bits clear, every channel's gamma switch reads 0, `pix_out_valid` is 0, and every table entry counts as lost.
- R2: Reading with `reg_sel`=0 returns the index register: bit 31 is auto-advance, bit 30 is keep-alive, bits 11:0 are the entry index, and all other bits are 0. A write with `reg_sel`=0 loads all three fields from `reg_wdata`.
- R3: A write with `reg_sel`=1 stores `reg_wdata[7:0]` at the current index. If auto-advance is set the index then grows by one. If auto-advance is clear the index does not change.
- R4: Auto-advance stops at index 2303: a write there stores the byte but leaves the index at 2303. A data write while the index is 2304 or more stores nothing and leaves the index unchanged.
- R5: The table entry for channel c, component k (red=0, green=1, blue=2) and input value v is at index c*768 + k*256 + v.
- R6: A write with `reg_sel`=2+c sets the gamma switch of channel c from `reg_wdata[0]`, and a read with that select returns it in bit 0. With the switch on, each component of the channel's pixel is replaced by its table entry.
- R7: With a channel's gamma switch off, the output pixel equals the input pixel.
- R8: `pix_out_valid[c]` follows `pix_in_valid[c]` one clock later, and the output pixel appears in that same cycle on both the lookup path and the bypass path.
- R9: On every clock edge where no gamma switch is on and keep-alive is clear, all entries become lost. A data write made in that state is not retained. A lookup of a lost entry returns 0x00, and rewriting the entry makes it valid again.
- R10: With keep-alive set, table contents survive a period in which no channel has gamma switched on.
- R11: A lookup in the same cycle as a write to the entry it reads returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 index, 1 data, 2..4 channel gamma switch |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| pix_in_valid | input | 3 | Per-channel input pixel valid |
| pix_in | input | 72 | Input pixels, channel c at bits [24c+23:24c], red in the top byte |
| pix_out_valid | output | 3 | Per-channel output pixel valid |
| pix_out | output | 72 | Output pixels, same layout as `pix_in` |

## Verification
The bench targets the index at the ends of the table space. A block that advanced past 2303 would wrap the index or overwrite the start of the next region. A block that stored data at an out-of-range index would corrupt an entry. It also removes power while the tables hold data and checks that lookups return zero afterwards and that a write made without power does not reappear. A block that kept stale contents would return old table values instead. A lookup that reads an entry in the same cycle that entry is written must return the value from before the write; a block that forwarded the new data would be off by one update. A long random run mixes index jumps, switch changes and pixel traffic across all three regions, so any error in the region base offsets shows up as a wrong component value.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  localparam int NUM_CH    = 3;
  localparam int NUM_COMP  = 3;
  localparam int COMP_W    = 8;
  localparam int LUT_DEPTH = 1 << COMP_W;
  localparam int CH_SPAN   = NUM_COMP * LUT_DEPTH;
  localparam int TOTAL     = NUM_CH * CH_SPAN;
  localparam int IDX_W     = $clog2(TOTAL);
  localparam int PIX_W     = NUM_COMP * COMP_W;
  localparam int REG_W     = 32;
  localparam int SEL_W     = 3;
  localparam int AINC_BIT  = REG_W - 1;
  localparam int KEEP_BIT  = REG_W - 2;

  localparam logic [SEL_W-1:0] SEL_INDEX = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_DATA  = SEL_W'(1);
  localparam int               SEL_SW0   = 2;
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(TOTAL - 1);
endpackage

// File: rtl/gamma_regs.sv
module gamma_regs
  import gamma_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [SEL_W-1:0]      reg_sel,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  output logic [IDX_W-1:0]      idx_q,
  output logic                  ainc_q,
  output logic                  keep_q,
  output logic [NUM_CH-1:0]     sw_q,
  output logic                  tbl_we,
  output logic [COMP_W-1:0]     tbl_wdata
);
  logic [IDX_W-1:0]  idx_d;
  logic              ainc_d;
  logic              keep_d;
  logic [NUM_CH-1:0] sw_d;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata[KEEP_BIT-1:IDX_W];
  assign tbl_wdata    = reg_wdata[COMP_W-1:0];

  always_comb begin
    idx_d  = idx_q;
    ainc_d = ainc_q;
    keep_d = keep_q;
    sw_d   = sw_q;
    tbl_we = 1'b0;
    if (reg_we) begin
      if (reg_sel == SEL_INDEX) begin
        idx_d  = reg_wdata[IDX_W-1:0];
        ainc_d = reg_wdata[AINC_BIT];
        keep_d = reg_wdata[KEEP_BIT];
      end else if (reg_sel == SEL_DATA) begin
        if (idx_q <= LAST_IDX) begin
          tbl_we = 1'b1;
          if (ainc_q && (idx_q != LAST_IDX)) idx_d = idx_q + 1'b1;
        end
      end else begin
        for (int c = 0; c < NUM_CH; c++)
          if (reg_sel == SEL_W'(SEL_SW0 + c)) sw_d[c] = reg_wdata[0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel == SEL_INDEX) begin
      reg_rdata[IDX_W-1:0] = idx_q;
      reg_rdata[AINC_BIT]  = ainc_q;
      reg_rdata[KEEP_BIT]  = keep_q;
    end else begin
      for (int c = 0; c < NUM_CH; c++)
        if (reg_sel == SEL_W'(SEL_SW0 + c)) reg_rdata[0] = sw_q[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      ainc_q <= 1'b0;
      keep_q <= 1'b0;
      sw_q   <= '0;
    end else if (reg_we) begin
      idx_q  <= idx_d;
      ainc_q <= ainc_d;
      keep_q <= keep_d;
      sw_q   <= sw_d;
    end
  end
endmodule

// File: rtl/gamma_store.sv
module gamma_store
  import gamma_pkg::*;
(
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       powered,
  input  logic                                       wr_en,
  input  logic [IDX_W-1:0]                           wr_idx,
  input  logic [COMP_W-1:0]                          wr_data,
  input  logic [NUM_CH-1:0][NUM_COMP-1:0][IDX_W-1:0] rd_idx,
  output logic [NUM_CH-1:0][NUM_COMP-1:0][COMP_W-1:0] rd_data,
  output logic                                       any_valid
);
  logic [COMP_W-1:0] mem_q [TOTAL];
  logic [TOTAL-1:0]  vld_q;
  logic              mem_wr;

  assign mem_wr    = wr_en && powered;
  assign any_valid = |vld_q;

  always_ff @(posedge clk) begin
    if (mem_wr) mem_q[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        vld_q <= '0;
    else if (!powered) vld_q <= '0;
    else if (mem_wr)   vld_q[wr_idx] <= 1'b1;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar k = 0; k < NUM_COMP; k++) begin : g_comp
      assign rd_data[c][k] = vld_q[rd_idx[c][k]] ? mem_q[rd_idx[c][k]] : '0;
    end
  end
endmodule

// File: rtl/gamma_pipe.sv
module gamma_pipe
  import gamma_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               in_valid,
  input  logic [PIX_W-1:0]                   in_pix,
  input  logic                               sw_on,
  input  logic [NUM_COMP-1:0][COMP_W-1:0]    lut_data,
  output logic [NUM_COMP-1:0][IDX_W-1:0]     lut_idx,
  output logic                               out_valid,
  output logic [PIX_W-1:0]                   out_pix
);
  logic [PIX_W-1:0] mapped;
  logic [PIX_W-1:0] pix_d;

  for (genvar k = 0; k < NUM_COMP; k++) begin : g_comp
    localparam int BASE = CH * CH_SPAN + k * LUT_DEPTH;
    localparam int HI   = PIX_W - 1 - k * COMP_W;
    assign lut_idx[k]              = IDX_W'(BASE) + IDX_W'(in_pix[HI -: COMP_W]);
    assign mapped[HI -: COMP_W]    = lut_data[k];
  end

  always_comb begin
    pix_d = sw_on ? mapped : in_pix;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_pix <= pix_d;
    end
  end
endmodule

// File: rtl/gamma_lut_top.sv
module gamma_lut_top
  import gamma_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [SEL_W-1:0]        reg_sel,
  input  logic [REG_W-1:0]        reg_wdata,
  output logic [REG_W-1:0]        reg_rdata,
  input  logic [NUM_CH-1:0]       pix_in_valid,
  input  logic [NUM_CH*PIX_W-1:0] pix_in,
  output logic [NUM_CH-1:0]       pix_out_valid,
  output logic [NUM_CH*PIX_W-1:0] pix_out
);
  logic [IDX_W-1:0]                            cur_idx;
  logic                                        cur_ainc;
  logic                                        cur_keep;
  logic [NUM_CH-1:0]                           gam_sw;
  logic                                        tbl_we;
  logic [COMP_W-1:0]                           tbl_wdata;
  logic                                        tbl_powered;
  logic                                        any_valid;
  logic [NUM_CH-1:0][NUM_COMP-1:0][IDX_W-1:0]  rd_idx;
  logic [NUM_CH-1:0][NUM_COMP-1:0][COMP_W-1:0] rd_data;

  assign tbl_powered = (|gam_sw) || cur_keep;

  gamma_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .idx_q     (cur_idx),
    .ainc_q    (cur_ainc),
    .keep_q    (cur_keep),
    .sw_q      (gam_sw),
    .tbl_we    (tbl_we),
    .tbl_wdata (tbl_wdata)
  );

  gamma_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .powered   (tbl_powered),
    .wr_en     (tbl_we),
    .wr_idx    (cur_idx),
    .wr_data   (tbl_wdata),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .any_valid (any_valid)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pipe
    gamma_pipe #(.CH(c)) u_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (pix_in_valid[c]),
      .in_pix    (pix_in[c*PIX_W +: PIX_W]),
      .sw_on     (gam_sw[c]),
      .lut_data  (rd_data[c]),
      .lut_idx   (rd_idx[c]),
      .out_valid (pix_out_valid[c]),
      .out_pix   (pix_out[c*PIX_W +: PIX_W])
    );
  end
endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk
  import gamma_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_we,
  input logic [SEL_W-1:0]        reg_sel,
  input logic [REG_W-1:0]        reg_wdata,
  input logic [REG_W-1:0]        reg_rdata,
  input logic [NUM_CH-1:0]       pix_in_valid,
  input logic [NUM_CH*PIX_W-1:0] pix_in,
  input logic [NUM_CH-1:0]       pix_out_valid,
  input logic [NUM_CH*PIX_W-1:0] pix_out,
  input logic [IDX_W-1:0]        cur_idx,
  input logic                    cur_ainc,
  input logic [NUM_CH-1:0]       gam_sw,
  input logic                    tbl_powered,
  input logic                    any_valid
);
  // R8
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pix_out_valid == $past(pix_in_valid)));

  // R3
  index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_DATA && cur_ainc && cur_idx < LAST_IDX)
    |=> (cur_idx == $past(cur_idx) + 1'b1));

  // R4
  index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_DATA && cur_idx >= LAST_IDX) |=> $stable(cur_idx));

  // R9
  power_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tbl_powered |=> !any_valid);

  // R2
  index_rdback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_INDEX)
    |=> (reg_sel != SEL_INDEX || reg_rdata[IDX_W-1:0] == $past(reg_wdata[IDX_W-1:0])));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_byp
    // R7
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_in_valid[c] && !gam_sw[c])
      |=> (pix_out[c*PIX_W +: PIX_W] == $past(pix_in[c*PIX_W +: PIX_W])));
  end
endmodule

bind gamma_lut_top gamma_lut_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_we        (reg_we),
  .reg_sel       (reg_sel),
  .reg_wdata     (reg_wdata),
  .reg_rdata     (reg_rdata),
  .pix_in_valid  (pix_in_valid),
  .pix_in        (pix_in),
  .pix_out_valid (pix_out_valid),
  .pix_out       (pix_out),
  .cur_idx       (cur_idx),
  .cur_ainc      (cur_ainc),
  .gam_sw        (gam_sw),
  .tbl_powered   (tbl_powered),
  .any_valid     (any_valid)
);

// File: tb/gamma_lut_top_test.sv
module gamma_lut_top_test;
  import gamma_pkg::*;

  logic                    clk;
  logic                    rst_n;
  logic                    reg_we;
  logic [SEL_W-1:0]        reg_sel;
  logic [REG_W-1:0]        reg_wdata;
  logic [REG_W-1:0]        reg_rdata;
  logic [NUM_CH-1:0]       pix_in_valid;
  logic [NUM_CH*PIX_W-1:0] pix_in;
  logic [NUM_CH-1:0]       pix_out_valid;
  logic [NUM_CH*PIX_W-1:0] pix_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [COMP_W-1:0] m_mem [TOTAL];
  bit                m_vld [TOTAL];
  int                m_idx;
  bit                m_ainc, m_keep;
  bit [NUM_CH-1:0]   m_sw;

  gamma_lut_top uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_in_valid(pix_in_valid),
    .pix_in(pix_in), .pix_out_valid(pix_out_valid), .pix_out(pix_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [REG_W-1:0] act, input logic [REG_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [PIX_W-1:0] ref_map(input int c, input logic [PIX_W-1:0] p);
    logic [PIX_W-1:0] r;
    if (!m_sw[c]) return p;
    for (int k = 0; k < NUM_COMP; k++) begin
      int v = int'(p[PIX_W-1-k*COMP_W -: COMP_W]);
      int i = c*CH_SPAN + k*LUT_DEPTH + v;
      r[PIX_W-1-k*COMP_W -: COMP_W] = m_vld[i] ? m_mem[i] : '0;
    end
    return r;
  endfunction

  // one clock: drive at negedge, check outputs at next negedge, then update model
  task automatic cycle(input bit we, input logic [SEL_W-1:0] sel, input logic [REG_W-1:0] wd,
                       input logic [NUM_CH-1:0] pv, input logic [NUM_CH*PIX_W-1:0] pd,
                       input string req);
    logic [PIX_W-1:0] exp_pix [NUM_CH];
    bit powered;
    for (int c = 0; c < NUM_CH; c++) exp_pix[c] = ref_map(c, pd[c*PIX_W +: PIX_W]);
    reg_we = we; reg_sel = sel; reg_wdata = wd; pix_in_valid = pv; pix_in = pd;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; pix_in_valid = '0;
    check({req, " R8 valid"}, REG_W'(pix_out_valid), REG_W'(pv));
    for (int c = 0; c < NUM_CH; c++)
      if (pv[c]) check(req, REG_W'(pix_out[c*PIX_W +: PIX_W]), REG_W'(exp_pix[c]));
    powered = (|m_sw) || m_keep;
    if (!powered) for (int i = 0; i < TOTAL; i++) m_vld[i] = 0;
    if (we) begin
      if (sel == SEL_INDEX) begin
        m_idx = int'(wd[IDX_W-1:0]); m_ainc = wd[AINC_BIT]; m_keep = wd[KEEP_BIT];
      end else if (sel == SEL_DATA) begin
        if (m_idx < TOTAL) begin
          if (powered) begin m_mem[m_idx] = wd[COMP_W-1:0]; m_vld[m_idx] = 1; end
          if (m_ainc && m_idx < TOTAL-1) m_idx++;
        end
      end else if (int'(sel) >= SEL_SW0 && int'(sel) < SEL_SW0 + NUM_CH) begin
        m_sw[int'(sel) - SEL_SW0] = wd[0];
      end
    end
  endtask

  task automatic wr(input logic [SEL_W-1:0] sel, input logic [REG_W-1:0] wd);
    cycle(1'b1, sel, wd, '0, '0, "wr");
  endtask

  task automatic read_check(input string req, input logic [SEL_W-1:0] sel);
    logic [REG_W-1:0] exp;
    reg_sel = sel;
    #1;
    exp = '0;
    if (sel == SEL_INDEX) begin
      exp[IDX_W-1:0] = IDX_W'(m_idx); exp[AINC_BIT] = m_ainc; exp[KEEP_BIT] = m_keep;
    end else if (int'(sel) >= SEL_SW0 && int'(sel) < SEL_SW0 + NUM_CH) begin
      exp[0] = m_sw[int'(sel) - SEL_SW0];
    end
    check(req, reg_rdata, exp);
  endtask

  function automatic logic [REG_W-1:0] idx_word(input bit ai, input bit kp, input int idx);
    logic [REG_W-1:0] w = '0;
    w[IDX_W-1:0] = IDX_W'(idx); w[AINC_BIT] = ai; w[KEEP_BIT] = kp;
    return w;
  endfunction

  function automatic logic [NUM_CH*PIX_W-1:0] rnd_pix();
    logic [NUM_CH*PIX_W-1:0] p;
    for (int c = 0; c < NUM_CH; c++) p[c*PIX_W +: PIX_W] = PIX_W'($urandom);
    return p;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
    pix_in_valid = '0; pix_in = '0;
    m_idx = 0; m_ainc = 0; m_keep = 0; m_sw = '0;
    for (int i = 0; i < TOTAL; i++) begin m_vld[i] = 0; m_mem[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 out valid", REG_W'(pix_out_valid), '0);
    read_check("R1 index reg", SEL_INDEX);
    for (int c = 0; c < NUM_CH; c++) read_check("R1 switch", SEL_W'(SEL_SW0 + c));

    // R1/R9 lookup before any load returns zero
    wr(SEL_W'(SEL_SW0), 32'd1);
    read_check("R6 switch readback", SEL_W'(SEL_SW0));
    cycle(0, '0, '0, 3'b001, {3{24'h12_80_FF}}, "R9 unloaded lookup");

    // R3/R5 load channel 0 with auto-advance
    wr(SEL_INDEX, idx_word(1, 0, 0));
    read_check("R2 index fields", SEL_INDEX);
    for (int i = 0; i < CH_SPAN; i++) wr(SEL_DATA, $urandom);
    read_check("R3 index after burst", SEL_INDEX);
    for (int n = 0; n < 8; n++) cycle(0, '0, '0, 3'b001, rnd_pix(), "R5 R6 ch0 lookup");

    // R3 without auto-advance
    wr(SEL_INDEX, idx_word(0, 0, 5));
    wr(SEL_DATA, 32'hAB);
    wr(SEL_DATA, 32'hCD);
    read_check("R3 index held", SEL_INDEX);
    cycle(0, '0, '0, 3'b001, {3{24'h05_00_00}}, "R3 last write wins");

    // R4 saturation at the top of the table
    wr(SEL_W'(SEL_SW0 + 2), 32'd1);
    wr(SEL_INDEX, idx_word(1, 0, TOTAL-2));
    wr(SEL_DATA, 32'h11);
    wr(SEL_DATA, 32'h22);
    wr(SEL_DATA, 32'h33);
    read_check("R4 index saturates", SEL_INDEX);
    cycle(0, '0, '0, 3'b100, {24'h00_FF_FE, 48'h0}, "R4 R5 top entries");

    // R4 out-of-range index ignored
    wr(SEL_INDEX, idx_word(1, 0, TOTAL+6));
    wr(SEL_DATA, 32'h77);
    read_check("R4 out of range index", SEL_INDEX);

    // R11 same-cycle write and lookup
    wr(SEL_INDEX, idx_word(1, 0, 0));
    cycle(1, SEL_DATA, 32'h5A, 3'b001, {3{24'h00_00_00}}, "R11 old value");
    cycle(0, '0, '0, 3'b001, {3{24'h00_00_00}}, "R11 new value");

    // R7 bypass on a switched-off channel
    cycle(0, '0, '0, 3'b010, rnd_pix(), "R7 bypass");
    cycle(0, '0, '0, 3'b111, rnd_pix(), "R7 R8 mixed");

    // R9 power loss
    wr(SEL_W'(SEL_SW0), 32'd0);
    wr(SEL_W'(SEL_SW0 + 2), 32'd0);
    wr(SEL_INDEX, idx_word(0, 0, 3));
    wr(SEL_DATA, 32'h99);
    wr(SEL_W'(SEL_SW0), 32'd1);
    cycle(0, '0, '0, 3'b001, {3{24'h03_40_00}}, "R9 lost after power off");
    wr(SEL_DATA, 32'h44);
    cycle(0, '0, '0, 3'b001, {3{24'h03_03_03}}, "R9 reload");

    // R10 keep-alive preserves contents
    wr(SEL_INDEX, idx_word(1, 1, 0));
    for (int i = 0; i < CH_SPAN; i++) wr(SEL_DATA, $urandom);
    wr(SEL_W'(SEL_SW0), 32'd0);
    repeat (4) cycle(0, '0, '0, '0, '0, "idle");
    wr(SEL_W'(SEL_SW0), 32'd1);
    for (int n = 0; n < 4; n++) cycle(0, '0, '0, 3'b001, rnd_pix(), "R10 kept");

    // full load of all channels then random traffic
    wr(SEL_INDEX, idx_word(1, 1, 0));
    for (int i = 0; i < TOTAL; i++) wr(SEL_DATA, $urandom);
    for (int n = 0; n < 3000; n++) begin
      int sr = int'($urandom % 100);
      bit we = sr < 35;
      logic [SEL_W-1:0] sel;
      logic [REG_W-1:0] wd = $urandom;
      if (sr < 3) begin
        sel = SEL_INDEX;
        wd = idx_word(wd[AINC_BIT], ($urandom % 4) != 0, int'($urandom % (TOTAL + 40)));
      end else if (sr < 10) sel = SEL_W'(SEL_SW0 + int'($urandom % NUM_CH));
      else sel = SEL_DATA;
      cycle(we, sel, wd, NUM_CH'($urandom), rnd_pix(), "R5 R6 R7 R9 random");
      if (n % 50 == 0) read_check("R2 R3 random index", SEL_INDEX);
    end

    finish_run();
  end
endmodule